// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block saves a processor's automatic interrupt context to a byte-wide stack memory when an interrupt is taken, and brings it back when the handler returns. On an accept strobe it captures the program counter, the flag word, the stack pointer and the register-bank select. It then writes a six-byte frame downward from the stack pointer, one byte per clock, and reports the lowered stack pointer. The program counter is zero-extended to 32 bits in the frame, which leaves one padding byte of zero.

On a return strobe it reads the same six bytes upward from the given stack pointer. The padding byte is read but discarded. It then hands back the program counter and flag word, the raised stack pointer, and the bank select that was captured at the most recent entry. General-purpose registers are left to software. Vector fetch and arbitration live elsewhere.

The controller is a five-state machine. The states are IDLE, PUSH (six write cycles), PUSH_COMMIT (one cycle to finalise the stack pointer), POP (six read cycles) and POP_COMMIT (one cycle to update the outputs). The transitions are:

- IDLE to PUSH on accept.
- IDLE to POP on return when accept is low.
- PUSH to PUSH_COMMIT after the sixth byte.
- POP to POP_COMMIT after the sixth byte.
- Both COMMIT states go to IDLE unconditionally.

Top module: `irq_ctx_seq`

## Requirements
- R1: Synchronous reset puts the block in IDLE with busy_o, done_o, mem_we_o and mem_re_o low, and sp_o, pc_o, flg_o and bank_o all zero; in IDLE no memory strobe is driven.
- R2: An accept strobe seen in IDLE starts six consecutive write cycles on the next cycle. Write k (k = 0..5) goes to address sp_i - 1 - k, where sp_i is the value captured with the strobe.
- R3: The six written bytes are, in order: flag bits 15:8, flag bits 7:0, 0x00, PC bits 23:16, PC bits 15:8, PC bits 7:0.
- R4: busy_o is high for exactly seven cycles per sequence (six memory cycles plus one commit cycle). After an entry, sp_o equals the captured stack pointer minus 6.
- R5: PC, flags, stack pointer and bank select are captured at the accept strobe. Changing those inputs during the entry alters neither the frame nor sp_o.
- R6: A return strobe seen in IDLE starts six consecutive read cycles on the next cycle. Read k goes to address sp_i + k. mem_rdata_i is taken in the same cycle as its read strobe, so memory read is combinational.
- R7: After a return, pc_o holds bytes 0..2 of the frame (low byte at the lowest address) and flg_o holds bytes 4..5. The byte at offset 3 has no effect on any output. sp_o equals the captured pointer plus 6.
- R8: After a return, bank_o equals the bank select captured at the most recent entry.
- R9: Accept and return strobes that arrive while busy_o is high are ignored, and memory reads and writes never occur in the same cycle.
- R10: When accept and return are both high in IDLE, the entry runs and the return is dropped.
- R11: done_o pulses for one cycle, in the first cycle that busy_o is low after a sequence; at that point sp_o, and for a return also pc_o, flg_o and bank_o, already hold their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accept_i | input | 1 | Interrupt accepted: start context save |
| return_i | input | 1 | Return from interrupt: start context restore |
| pc_i | input | 24 | Program counter to save |
| flg_i | input | 16 | Flag word to save |
| sp_i | input | 24 | Current stack pointer |
| bank_i | input | 1 | Active register-bank select |
| mem_we_o | output | 1 | Stack memory write strobe |
| mem_re_o | output | 1 | Stack memory read strobe |
| mem_addr_o | output | 24 | Stack memory byte address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read (valid in the read cycle) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 24 | Updated stack pointer |
| pc_o | output | 24 | Restored program counter |
| flg_o | output | 16 | Restored flag word |
| bank_o | output | 1 | Restored register-bank select |

## Verification
The hardest behaviour to reach from the ports is that the frame and the outputs are immune to disturbance while a sequence runs. This covers input changes during the push, stray strobes in the middle of either sequence, a simultaneous accept and return, and a nonzero value in the padding slot. The stimulus reaches these cases by driving the disturbance on named cycles inside a running sequence. It changes PC, flags, pointer and bank right after the strobe, pulses both strobes in the third push cycle, and pulses accept in the second pop cycle. Before one return, the bench's memory model plants 0xA5 in the padding slot. After each sequence the bench checks the memory traffic byte by byte, checks the busy length, and checks that no spurious sequence follows.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

    // Controller states of the context sequencer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PUSH_COMMIT,
        ST_POP,
        ST_POP_COMMIT
    } ctx_state_e;

    // The program counter always occupies this many bits in the frame
    localparam int unsigned PC_SLOT_W = 32;

    // Bytes in one frame for a given flag width
    function automatic int unsigned frame_bytes(input int unsigned flg_w);
        return (flg_w / 8) + (PC_SLOT_W / 8);
    endfunction

endpackage

// File: rtl/ctx_step_ctr.sv
module ctx_step_ctr #(
    parameter int unsigned COUNT = 6,
    localparam int unsigned IW   = $clog2(COUNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    output logic [IW-1:0] idx_o,
    output logic          last_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(COUNT - 1);

    always_ff @(posedge clk) begin
        if (rst || !step_i) begin
            idx_o <= '0;
        end else if (idx_o == LAST_IDX) begin
            idx_o <= '0;
        end else begin
            idx_o <= idx_o + 1'b1;
        end
    end

    assign last_o = step_i && (idx_o == LAST_IDX);

endmodule

// File: rtl/ctx_fsm.sv
module ctx_fsm
    import irq_ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept_i,
    input  logic       return_i,
    input  logic       last_i,
    output ctx_state_e state_o
);

    ctx_state_e state_nx;

    always_comb begin
        state_nx = state_o;
        unique case (state_o)
            ST_IDLE: begin
                if (accept_i) begin
                    state_nx = ST_PUSH;
                end else if (return_i) begin
                    state_nx = ST_POP;
                end
            end
            ST_PUSH:        if (last_i) state_nx = ST_PUSH_COMMIT;
            ST_PUSH_COMMIT: state_nx = ST_IDLE;
            ST_POP:         if (last_i) state_nx = ST_POP_COMMIT;
            ST_POP_COMMIT:  state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= ST_IDLE;
        end else begin
            state_o <= state_nx;
        end
    end

endmodule

// File: rtl/ctx_frame_capture.sv
module ctx_frame_capture #(
    parameter int unsigned PC_W  = 24,
    parameter int unsigned FLG_W = 16,
    localparam int unsigned FB   = irq_ctx_pkg::frame_bytes(FLG_W),
    localparam int unsigned IW   = $clog2(FB),
    localparam int unsigned PCB  = (PC_W + 7) / 8,
    localparam int unsigned FLB  = FLG_W / 8,
    localparam int unsigned FLG0 = irq_ctx_pkg::PC_SLOT_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [IW-1:0]    idx_i,
    input  logic [7:0]       byte_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [FLG_W-1:0] flg_o
);

    logic [PCB*8-1:0] pc_r;
    logic [FLG_W-1:0] flg_r;

    // Program counter bytes sit at the lowest frame offsets
    for (genvar k = 0; k < PCB; k++) begin : g_pc_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                pc_r[k*8 +: 8] <= '0;
            end else if (load_i && idx_i == IW'(k)) begin
                pc_r[k*8 +: 8] <= byte_i;
            end
        end
    end

    // Flag bytes sit above the 32-bit PC slot; padding offsets load nothing
    for (genvar j = 0; j < FLB; j++) begin : g_flg_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                flg_r[j*8 +: 8] <= '0;
            end else if (load_i && idx_i == IW'(FLG0 + j)) begin
                flg_r[j*8 +: 8] <= byte_i;
            end
        end
    end

    assign pc_o  = pc_r[PC_W-1:0];
    assign flg_o = flg_r;

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int unsigned PC_W  = 24,
    parameter int unsigned FLG_W = 16,
    parameter int unsigned SP_W  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             return_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [FLG_W-1:0] flg_i,
    input  logic [SP_W-1:0]  sp_i,
    input  logic             bank_i,
    output logic             mem_we_o,
    output logic             mem_re_o,
    output logic [SP_W-1:0]  mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    input  logic [7:0]       mem_rdata_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [SP_W-1:0]  sp_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [FLG_W-1:0] flg_o,
    output logic             bank_o
);

    localparam int unsigned FB      = frame_bytes(FLG_W);
    localparam int unsigned IW      = $clog2(FB);
    localparam int unsigned FRAME_W = FB * 8;
    localparam logic [SP_W-1:0] FRAME_LEN = SP_W'(FB);

    ctx_state_e         state;
    logic [IW-1:0]      idx;
    logic               last;
    logic               stepping;
    logic               start_ok;

    logic [PC_W-1:0]    pc_q;
    logic [FLG_W-1:0]   flg_q;
    logic [SP_W-1:0]    sp_q;
    logic               bank_save_q;

    logic [FRAME_W-1:0] frame_push;
    logic [7:0]         push_bytes [FB];
    logic [PC_W-1:0]    pc_cap;
    logic [FLG_W-1:0]   flg_cap;

    assign stepping = (state == ST_PUSH) || (state == ST_POP);
    assign start_ok = (state == ST_IDLE);

    ctx_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept_i),
        .return_i (return_i),
        .last_i   (last),
        .state_o  (state)
    );

    ctx_step_ctr #(.COUNT(FB)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .step_i (stepping),
        .idx_o  (idx),
        .last_o (last)
    );

    ctx_frame_capture #(.PC_W(PC_W), .FLG_W(FLG_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .load_i (state == ST_POP),
        .idx_i  (idx),
        .byte_i (mem_rdata_i),
        .pc_o   (pc_cap),
        .flg_o  (flg_cap)
    );

    // Frame image, most significant byte first in push order
    assign frame_push = {flg_q, PC_SLOT_W'(pc_q)};

    for (genvar k = 0; k < FB; k++) begin : g_push_sel
        assign push_bytes[k] = frame_push[(FB-1-k)*8 +: 8];
    end

    // Capture of context at the starting strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q        <= '0;
            flg_q       <= '0;
            sp_q        <= '0;
            bank_save_q <= 1'b0;
        end else if (start_ok && accept_i) begin
            pc_q        <= pc_i;
            flg_q       <= flg_i;
            sp_q        <= sp_i;
            bank_save_q <= bank_i;
        end else if (start_ok && return_i) begin
            sp_q        <= sp_i;
        end
    end

    // Registered results, updated on leaving a commit state
    always_ff @(posedge clk) begin
        if (rst) begin
            sp_o   <= '0;
            pc_o   <= '0;
            flg_o  <= '0;
            bank_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_PUSH_COMMIT: begin
                    sp_o   <= sp_q - FRAME_LEN;
                    done_o <= 1'b1;
                end
                ST_POP_COMMIT: begin
                    sp_o   <= sp_q + FRAME_LEN;
                    pc_o   <= pc_cap;
                    flg_o  <= flg_cap;
                    bank_o <= bank_save_q;
                    done_o <= 1'b1;
                end
                ST_IDLE, ST_PUSH, ST_POP: ;
                default: ;
            endcase
        end
    end

    // Memory port and busy, decoded from state and byte index
    always_comb begin
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        busy_o      = 1'b1;
        unique case (state)
            ST_IDLE: busy_o = 1'b0;
            ST_PUSH: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - SP_W'(idx) - SP_W'(1);
                mem_wdata_o = push_bytes[idx];
            end
            ST_POP: begin
                mem_re_o   = 1'b1;
                mem_addr_o = sp_q + SP_W'(idx);
            end
            ST_PUSH_COMMIT, ST_POP_COMMIT: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk #(
    parameter int unsigned PC_W  = 24,
    parameter int unsigned FLG_W = 16,
    parameter int unsigned SP_W  = 24
) (
    input logic            clk,
    input logic            rst,
    input logic            accept_i,
    input logic            return_i,
    input logic [SP_W-1:0] sp_i,
    input logic            mem_we_o,
    input logic            mem_re_o,
    input logic [SP_W-1:0] mem_addr_o,
    input logic [7:0]      mem_wdata_o,
    input logic            busy_o,
    input logic            done_o,
    input logic [SP_W-1:0] sp_o
);

    localparam int unsigned FB      = irq_ctx_pkg::frame_bytes(FLG_W);
    localparam int unsigned PAD_IDX = FLG_W / 8;
    localparam int unsigned PC_USED = (PC_W + 7) / 8;

    logic [SP_W-1:0] rec_sp;
    logic            rec_push;
    logic [7:0]      busy_cnt;
    logic [7:0]      wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_sp   <= '0;
            rec_push <= 1'b0;
            busy_cnt <= '0;
            wr_cnt   <= '0;
        end else begin
            if (!busy_o && accept_i) begin
                rec_sp   <= sp_i;
                rec_push <= 1'b1;
            end else if (!busy_o && return_i) begin
                rec_sp   <= sp_i;
                rec_push <= 1'b0;
            end
            busy_cnt <= busy_o ? busy_cnt + 1'b1 : '0;
            if (mem_we_o) begin
                wr_cnt <= wr_cnt + 1'b1;
            end else if (!busy_o) begin
                wr_cnt <= '0;
            end
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_we_o && !mem_re_o));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (accept_i || return_i)) |=> busy_o);

    a_r2_write_descend: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - 1'b1));

    a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && wr_cnt == 8'(PAD_IDX) && PAD_IDX >= PC_USED - PC_USED)
            |-> (mem_wdata_o == 8'h00));

    a_r4_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_cnt == 8'(FB + 1)));

    a_r4_sp_after_push: assert property (@(posedge clk) disable iff (rst)
        (done_o && rec_push) |-> (sp_o == rec_sp - SP_W'(FB)));

    a_r6_read_ascend: assert property (@(posedge clk) disable iff (rst)
        (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

    a_r7_sp_after_pop: assert property (@(posedge clk) disable iff (rst)
        (done_o && !rec_push) |-> (sp_o == rec_sp + SP_W'(FB)));

    a_r9_port_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we_o && mem_re_o));

    a_r11_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(
    .PC_W  (PC_W),
    .FLG_W (FLG_W),
    .SP_W  (SP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .accept_i    (accept_i),
    .return_i    (return_i),
    .sp_i        (sp_i),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .sp_o        (sp_o)
);

// File: tb/irq_ctx_seq_tb.sv
`timescale 1ns/1ps
module irq_ctx_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        accept_i = 1'b0;
    logic        return_i = 1'b0;
    logic [23:0] pc_i = '0;
    logic [15:0] flg_i = '0;
    logic [23:0] sp_i = '0;
    logic        bank_i = 1'b0;
    logic        mem_we_o, mem_re_o;
    logic [23:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        busy_o, done_o;
    logic [23:0] sp_o, pc_o;
    logic [15:0] flg_o;
    logic        bank_o;

    logic [7:0]  mem [256];
    int          n_checks = 0;
    int          n_fail   = 0;

    always #2.5 clk = ~clk;

    irq_ctx_seq u_dut (
        .clk(clk), .rst(rst), .accept_i(accept_i), .return_i(return_i),
        .pc_i(pc_i), .flg_i(flg_i), .sp_i(sp_i), .bank_i(bank_i),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o), .pc_o(pc_o),
        .flg_o(flg_o), .bank_o(bank_o)
    );

    // Byte memory model: registered write, combinational read
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    end
    assign mem_rdata_i = mem[mem_addr_o[7:0]];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R1", "busy/done in reset", {busy_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_we_o && !mem_re_o, "R1", "mem strobes", {mem_we_o, mem_re_o}, 0);
        check(sp_o == 0 && pc_o == 0, "R1", "sp/pc after reset", sp_o | pc_o, 0);
        check(flg_o == 0 && !bank_o, "R1", "flg/bank after reset", {flg_o, bank_o}, 0);
    endtask

    // R2 R3 R4 R5 R9 R10 R11: context save
    task automatic t_entry(input logic [23:0] pc, input logic [15:0] flg,
                           input logic [23:0] sp, input bit bank,
                           input bit corrupt, input bit disturb, input bit with_ret);
        logic [7:0] exp_b [6];
        int         busy_n = 0;
        exp_b[0] = flg[15:8]; exp_b[1] = flg[7:0]; exp_b[2] = 8'h00;
        exp_b[3] = pc[23:16]; exp_b[4] = pc[15:8]; exp_b[5] = pc[7:0];
        @(negedge clk);
        pc_i = pc; flg_i = flg; sp_i = sp; bank_i = bank;
        accept_i = 1'b1; return_i = with_ret;
        @(negedge clk);
        accept_i = 1'b0; return_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (busy_o) busy_n++;
            check(mem_we_o && !mem_re_o, with_ret ? "R10" : "R2", "write strobe",
                  {mem_we_o, mem_re_o}, 2'b10);
            check(mem_addr_o == sp - 24'(k) - 24'd1, "R2", "write address",
                  mem_addr_o, sp - 24'(k) - 24'd1);
            check(mem_wdata_o == exp_b[k], corrupt ? "R5" : "R3", "frame byte",
                  mem_wdata_o, exp_b[k]);
            if (corrupt && k == 0) begin
                pc_i = ~pc; flg_i = ~flg; sp_i = sp + 24'd40; bank_i = ~bank;
            end
            if (disturb && k == 2) begin accept_i = 1'b1; return_i = 1'b1; end
            if (disturb && k == 3) begin accept_i = 1'b0; return_i = 1'b0; end
            @(negedge clk);
        end
        if (busy_o) busy_n++;
        check(!mem_we_o && !mem_re_o, "R4", "commit cycle quiet", {mem_we_o, mem_re_o}, 0);
        @(negedge clk);
        check(busy_n == 7 && !busy_o, "R4", "busy length", busy_n, 7);
        check(done_o, "R11", "done pulse", done_o, 1);
        check(sp_o == sp - 24'd6, corrupt ? "R5" : "R4", "sp after entry", sp_o, sp - 24'd6);
        @(negedge clk);
        check(!done_o && !busy_o && !mem_re_o, disturb ? "R9" : "R11",
              "no retrigger", {done_o, busy_o, mem_re_o}, 0);
    endtask

    // R6 R7 R8 R9 R11: context restore
    task automatic t_return(input logic [23:0] sp, input logic [23:0] exp_pc,
                            input logic [15:0] exp_flg, input bit exp_bank,
                            input bit disturb);
        @(negedge clk);
        sp_i = sp; return_i = 1'b1;
        @(negedge clk);
        return_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check(mem_re_o && !mem_we_o, disturb ? "R9" : "R6", "read strobe",
                  {mem_re_o, mem_we_o}, 2'b10);
            check(mem_addr_o == sp + 24'(k), "R6", "read address", mem_addr_o, sp + 24'(k));
            if (disturb && k == 1) accept_i = 1'b1;
            if (disturb && k == 2) accept_i = 1'b0;
            @(negedge clk);
        end
        check(busy_o && !mem_re_o, "R6", "commit cycle", {busy_o, mem_re_o}, 2'b10);
        @(negedge clk);
        check(done_o && !busy_o, "R11", "done after return", {done_o, busy_o}, 2'b10);
        check(pc_o == exp_pc, "R7", "restored pc", pc_o, exp_pc);
        check(flg_o == exp_flg, "R7", "restored flags", flg_o, exp_flg);
        check(sp_o == sp + 24'd6, "R7", "sp after return", sp_o, sp + 24'd6);
        check(bank_o == exp_bank, "R8", "restored bank", bank_o, exp_bank);
        @(negedge clk);
        check(!busy_o && !mem_we_o, "R9", "no entry from stray accept", {busy_o, mem_we_o}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset();
        // Entry with inputs corrupted after the strobe, then plain return
        t_entry(24'h123456, 16'hBEEF, 24'h000080, 1'b1, 1'b1, 1'b0, 1'b0);
        t_return(24'h00007A, 24'h123456, 16'hBEEF, 1'b1, 1'b0);
        // Entry with strobes pulsed mid-sequence
        t_entry(24'hABCDEF, 16'h1234, 24'h0000C0, 1'b0, 1'b0, 1'b1, 1'b0);
        // Nonzero pad byte must not matter (R7), accept during pop ignored
        mem[8'hBA + 8'd3] = 8'hA5;
        t_return(24'h0000BA, 24'hABCDEF, 16'h1234, 1'b0, 1'b1);
        // Accept and return together: entry wins
        t_entry(24'h00FF00, 16'h8001, 24'h000040, 1'b1, 1'b0, 1'b0, 1'b1);
        t_return(24'h00003A, 24'h00FF00, 16'h8001, 1'b1, 1'b0);
        finish_run();
    end

endmodule